// File: doc/BRIEF.md
# Wide-Immediate Quarter Insertion Unit

This unit executes the two wide-immediate move operations of a 64-bit core. Each operation places a 16-bit constant into one chosen 16-bit quarter of a destination register. The other three quarters are either cleared or carried over from the register's current contents. A 64-bit constant is assembled with one clearing move followed by up to three preserving moves, one for each remaining quarter.

The unit takes a qualified 32-bit instruction word and the current destination register value, which the surrounding core reads out of its register file. One clock later it presents a registered write request: a write enable, the destination index and the 64-bit result. If the word is not one of the two move encodings, or it is not qualified, no write is requested and the result outputs keep their previous values.

Inside the unit, a decoder derives a small strobe struct that says whether to write and whether to preserve the other quarters. A datapath performs the quarter merge and holds the output registers.

Top module: `wide_imm_insert`

## Requirements
- R1: While `rstN` is low, `wrEn`, `wrIdx` and `wrData` are all zero.
- R2: Instruction fields are laid out as follows: opcode in bits 31:23, quarter select in bits 22:21, immediate in bits 20:5, destination index in bits 4:0. Quarter select value q addresses result bits 16q+15 down to 16q.
- R3: Opcode 9'h1A5 is the clearing move. The result is the immediate in the selected quarter and zero in the other three quarters.
- R4: Opcode 9'h1E5 is the preserving move. The result is the immediate in the selected quarter, and the other three quarters are copied from `oldValue`.
- R5: A qualified instruction with either move opcode raises `wrEn` on the following cycle, with `wrIdx` equal to its destination field.
- R6: An instruction with any other opcode, or any word presented with `instrValid` low, leaves `wrEn` low on the following cycle and leaves `wrData` and `wrIdx` unchanged.
- R7: Moves issued back to back each produce their own result on the cycle after they are presented, with no dead cycles between them.
- R8: One clearing move followed by preserving moves that take the previous result as `oldValue` builds any 64-bit constant, whatever order the quarters are written in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Qualifies `instrWord` in this cycle |
| instrWord | input | 32 | Instruction word |
| oldValue | input | 64 | Current value of the destination register |
| wrEn | output | 1 | Register write request |
| wrIdx | output | 5 | Destination register index |
| wrData | output | 64 | New destination register value |

## Verification
The assertions assume that `oldValue` is the destination register's contents in the same cycle as the instruction. They also assume that the quarter select always addresses a quarter that exists, which holds when the data width is a power-of-two multiple of the immediate width. The bench supplies `oldValue` explicitly for every operation. In the chained-build tests it feeds the previously registered result back as `oldValue`, which is how the core's forwarding would behave. Stimulus changes only on falling edges, so each operation's inputs are stable at the capturing edge.

// File: rtl/wide_imm_pkg.sv
package wide_imm_pkg;
  localparam int DataW   = 64;
  localparam int ImmW    = 16;
  localparam int OpcW    = 9;
  localparam int RegIdxW = 5;
  localparam int Lanes   = DataW / ImmW;
  localparam int SelW    = $clog2(Lanes);
  localparam int InstrW  = OpcW + SelW + ImmW + RegIdxW;

  localparam logic [OpcW-1:0] ZeroOpc = 9'h1A5;
  localparam logic [OpcW-1:0] KeepOpc = 9'h1E5;

  typedef struct packed {
    logic write;
    logic keep;
  } moveCtl_t;
endpackage

// File: rtl/wide_imm_decode.sv
module wide_imm_decode
  import wide_imm_pkg::*;
#(
  parameter int OPC_W = OpcW,
  parameter int SEL_W = SelW,
  parameter int IMM_W = ImmW,
  parameter int IDX_W = RegIdxW,
  parameter logic [OPC_W-1:0] ZERO_OPC = ZeroOpc,
  parameter logic [OPC_W-1:0] KEEP_OPC = KeepOpc,
  localparam int INSTR_W = OPC_W + SEL_W + IMM_W + IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output moveCtl_t           ctl,
  output logic [SEL_W-1:0]   laneSel,
  output logic [IMM_W-1:0]   immField,
  output logic [IDX_W-1:0]   dstIdx
);
  localparam int IdxLo = 0;
  localparam int ImmLo = IdxLo + IDX_W;
  localparam int SelLo = ImmLo + IMM_W;
  localparam int OpcLo = SelLo + SEL_W;

  logic [OPC_W-1:0] opcField;
  logic isZero;
  logic isKeep;

  always_comb begin
    opcField = instrWord[OpcLo +: OPC_W];
    laneSel  = instrWord[SelLo +: SEL_W];
    immField = instrWord[ImmLo +: IMM_W];
    dstIdx   = instrWord[IdxLo +: IDX_W];
    isZero   = (opcField == ZERO_OPC);
    isKeep   = (opcField == KEEP_OPC);
    ctl.write = instrValid && (isZero || isKeep);
    ctl.keep  = isKeep;
  end

  // R6
  foreign_opc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[OpcLo +: OPC_W] != ZERO_OPC && instrWord[OpcLo +: OPC_W] != KEEP_OPC) |-> !ctl.write);

  // R6
  unqualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !ctl.write);
endmodule

// File: rtl/wide_imm_datapath.sv
module wide_imm_datapath
  import wide_imm_pkg::*;
#(
  parameter int DATA_W = DataW,
  parameter int IMM_W  = ImmW,
  parameter int IDX_W  = RegIdxW,
  localparam int LANES = DATA_W / IMM_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  moveCtl_t          ctl,
  input  logic [SEL_W-1:0]  laneSel,
  input  logic [IMM_W-1:0]  immField,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] oldValue,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] selMask;
  logic [DATA_W-1:0] immRep;
  logic [DATA_W-1:0] nextData;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign selMask[lane*IMM_W +: IMM_W] = {IMM_W{laneSel == SEL_W'(lane)}};
    assign immRep[lane*IMM_W +: IMM_W]  = immField;
  end

  always_comb begin
    nextData = immRep & selMask;
    if (ctl.keep) nextData = nextData | (oldValue & ~selMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrIdx  <= '0;
      wrData <= '0;
    end else begin
      wrEn <= ctl.write;
      if (ctl.write) begin
        wrIdx  <= dstIdx;
        wrData <= nextData;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (!wrEn && wrIdx == '0 && wrData == '0));

  // R5
  write_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.write |=> (wrEn && wrIdx == $past(dstIdx)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.write |=> (!wrEn && $stable(wrData) && $stable(wrIdx)));

  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.write && !ctl.keep) |=> ((wrData & ~$past(selMask)) == '0));

  // R4
  keep_others_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.write && ctl.keep) |=>
      ((wrData & ~$past(selMask)) == ($past(oldValue) & ~$past(selMask))));

  // R2
  lane_place_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.write |=> ((wrData & $past(selMask)) == ($past(immRep) & $past(selMask))));
endmodule

// File: rtl/wide_imm_insert.sv
module wide_imm_insert
  import wide_imm_pkg::*;
#(
  parameter int DATA_W = DataW,
  parameter int IMM_W  = ImmW,
  parameter int OPC_W  = OpcW,
  parameter int IDX_W  = RegIdxW,
  parameter logic [OPC_W-1:0] ZERO_OPC = ZeroOpc,
  parameter logic [OPC_W-1:0] KEEP_OPC = KeepOpc,
  localparam int LANES   = DATA_W / IMM_W,
  localparam int SEL_W   = $clog2(LANES),
  localparam int INSTR_W = OPC_W + SEL_W + IMM_W + IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  oldValue,
  output logic               wrEn,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [DATA_W-1:0]  wrData
);
  moveCtl_t         ctl;
  logic [SEL_W-1:0] laneSel;
  logic [IMM_W-1:0] immField;
  logic [IDX_W-1:0] dstIdx;

  wide_imm_decode #(
    .OPC_W(OPC_W), .SEL_W(SEL_W), .IMM_W(IMM_W), .IDX_W(IDX_W),
    .ZERO_OPC(ZERO_OPC), .KEEP_OPC(KEEP_OPC)
  ) u_decode (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .ctl(ctl), .laneSel(laneSel), .immField(immField), .dstIdx(dstIdx)
  );

  wide_imm_datapath #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .laneSel(laneSel), .immField(immField),
    .dstIdx(dstIdx), .oldValue(oldValue),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );
endmodule

// File: tb/tb_wide_imm_insert.sv
module tb_wide_imm_insert;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] oldValue = '0;
  logic        wrEn;
  logic [4:0]  wrIdx;
  logic [63:0] wrData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] mData = '0;
  logic [4:0]  mIdx = '0;

  localparam logic [8:0] OPC_Z = 9'h1A5;
  localparam logic [8:0] OPC_K = 9'h1E5;

  wide_imm_insert dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .oldValue(oldValue), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  always #10 clk = ~clk;

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modelMove(input logic keep, input logic [1:0] sel,
                                            input logic [15:0] imm, input logic [63:0] old);
    logic [63:0] m;
    logic [63:0] v;
    m = 64'hFFFF << (16 * sel);
    v = {48'h0, imm} << (16 * sel);
    return keep ? ((old & ~m) | v) : v;
  endfunction

  // Drives on a falling edge, checks on the next falling edge, then drops valid.
  task automatic runOp(input logic v, input logic [8:0] opc, input logic [1:0] sel,
                       input logic [15:0] imm, input logic [4:0] rd,
                       input logic [63:0] old, input string req);
    logic hit;
    @(negedge clk);
    instrValid = v;
    instrWord  = {opc, sel, imm, rd};
    oldValue   = old;
    hit = v && (opc == OPC_Z || opc == OPC_K);
    if (hit) begin
      mData = modelMove(opc == OPC_K, sel, imm, old);
      mIdx  = rd;
    end
    @(negedge clk);
    checkVal({req, " wrEn"}, {63'h0, wrEn}, {63'h0, hit});
    checkVal({req, " wrIdx"}, {59'h0, wrIdx}, {59'h0, mIdx});
    checkVal({req, " wrData"}, wrData, mData);
    instrValid = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h8001};
    logic [63:0] olds [3] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1357_9BDF_2468_ACE0};
    logic [8:0]  bad  [6] = '{9'h000, 9'h1FF, 9'h125, 9'h1A4, 9'h1E4, 9'h0A5};
    logic [63:0] acc;

    // R1: outputs clear while reset is held, even with a qualified move
    instrValid = 1'b1;
    instrWord  = {OPC_Z, 2'd1, 16'hBEEF, 5'd7};
    repeat (3) @(negedge clk);
    checkVal("R1 wrEn", {63'h0, wrEn}, 64'h0);
    checkVal("R1 wrIdx", {59'h0, wrIdx}, 64'h0);
    checkVal("R1 wrData", wrData, 64'h0);
    instrValid = 1'b0;
    rstN = 1'b1;

    // R2 R3 R4 R5: sweep both variants, every quarter, several immediates and old values
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 4; i++)
          for (int o = 0; o < 3; o++)
            runOp(1'b1, k ? OPC_K : OPC_Z, 2'(s), imms[i], 5'(s * 7 + i + o),
                  olds[o], k ? "R4 keep R2" : "R3 zero R2");

    // R6: foreign opcodes leave the outputs untouched
    for (int b = 0; b < 6; b++)
      runOp(1'b1, bad[b], 2'(b), 16'h7E7E, 5'd30, 64'hDEAD_BEEF_0BAD_F00D, "R6 opcode");

    // R6: a move with valid low is ignored
    runOp(1'b0, OPC_Z, 2'd2, 16'h1111, 5'd3, 64'h0, "R6 unqualified");
    runOp(1'b0, OPC_K, 2'd0, 16'h2222, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R6 unqualified");

    // R7: back-to-back moves, one result per cycle
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = {OPC_Z, 2'd0, 16'h00AA, 5'd9};
    oldValue   = 64'h0;
    @(negedge clk);
    checkVal("R7 first", wrData, 64'h0000_0000_0000_00AA);
    instrWord  = {OPC_K, 2'd3, 16'h5500, 5'd10};
    oldValue   = 64'h1111_2222_3333_4444;
    @(negedge clk);
    checkVal("R7 second", wrData, 64'h5500_2222_3333_4444);
    checkVal("R7 second idx", {59'h0, wrIdx}, 64'd10);
    instrValid = 1'b0;
    mData = 64'h5500_2222_3333_4444;
    mIdx  = 5'd10;

    // R8: build constants by chaining, high-to-low and scrambled order
    runOp(1'b1, OPC_Z, 2'd3, 16'h0123, 5'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R8 chain");
    runOp(1'b1, OPC_K, 2'd2, 16'h4567, 5'd5, wrData, "R8 chain");
    runOp(1'b1, OPC_K, 2'd1, 16'h89AB, 5'd5, wrData, "R8 chain");
    runOp(1'b1, OPC_K, 2'd0, 16'hCDEF, 5'd5, wrData, "R8 chain");
    checkVal("R8 final", wrData, 64'h0123_4567_89AB_CDEF);
    acc = 64'h0;
    runOp(1'b1, OPC_Z, 2'd1, 16'hC0DE, 5'd6, 64'hAAAA_AAAA_AAAA_AAAA, "R8 chain");
    runOp(1'b1, OPC_K, 2'd3, 16'hFACE, 5'd6, wrData, "R8 chain");
    runOp(1'b1, OPC_K, 2'd0, 16'h0042, 5'd6, wrData, "R8 chain");
    acc = wrData;
    checkVal("R8 partial", acc, 64'hFACE_0000_C0DE_0042);

    // R1: asynchronous reset mid-run clears outputs at once
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = {OPC_Z, 2'd2, 16'h9999, 5'd12};
    rstN = 1'b0;
    #1;
    checkVal("R1 midrun data", wrData, 64'h0);
    checkVal("R1 midrun en", {63'h0, wrEn}, 64'h0);
    @(negedge clk);
    instrValid = 1'b0;
    rstN = 1'b1;
    mData = '0;
    mIdx  = '0;
    runOp(1'b1, OPC_K, 2'd2, 16'h9999, 5'd12, 64'h0, "R4 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule